// File: doc/BRIEF.md
# Nibble Data-Memory Execution Unit

This block carries out the memory-reference instructions of a 4-bit processor core. It owns the 4-bit accumulator and the carry/link bit. It also owns a latched 8-bit character pointer and a 3-bit bank selector. Together these address a banked data memory of 4-bit characters, plus a small side store of four status nibbles for each memory register. The decode stage presents an 8-bit opcode with a valid strobe. The block finishes the instruction at the next clock edge and pulses `done_o` for one cycle.

The rest of the core sets up the block through three load ports:
- the pointer, which the core's address-send instruction writes;
- the bank, which the core's bank-select instruction writes;
- the accumulator and carry, which the core writes back from its other instructions.

Arithmetic supports two modes. In add mode the memory nibble and the carry are added to the accumulator. In subtract mode the one's complement of the nibble and the inverted carry are added instead. After a subtract, carry = 1 means no borrow.

Top module: `nram_exec_unit`

## Requirements
- R1: When the asynchronous active-low reset is applied, the accumulator, carry, character pointer and bank all clear to zero, and `done_o` is low.
- R2: The selected data character is addressed by bank, chip (pointer[7:6]), register (pointer[5:4]) and character (pointer[3:0]). Characters that differ in any one of these fields are stored independently.
- R3: Opcode 8'hE0 writes the accumulator into the selected character and leaves the accumulator and carry unchanged.
- R4: Opcode 8'hE9 loads the selected character into the accumulator and leaves the carry unchanged.
- R5: Opcode 8'hE8 sets the accumulator to (acc + mem + carry) mod 16. It sets carry to 1 when that sum exceeds 15 and clears it otherwise.
- R6: Opcode 8'hEA sets the accumulator to (acc + ~mem + ~carry) mod 16, and carry to the carry-out of that 5-bit sum. Carry = 1 means no borrow, and carry = 1 on entry means a borrow is pending.
- R7: The add and subtract opcodes never modify the data character they read.
- R8: The status nibbles of a register are addressed by bank, chip and register, with the index taken from opcode[1:0].
  - Opcode 8'b1110_01xx writes the accumulator to status nibble xx.
  - Opcode 8'b1110_11xx loads status nibble xx into the accumulator.
  - The status store is separate from the data characters.
- R9: `done_o` is high for exactly the one cycle after each accepted recognised opcode, and the accumulator and carry change at that same edge.
- R10: An opcode outside the set above, even when presented with valid, changes neither the accumulator, the carry nor memory, and raises no `done_o`.
- R11: The pointer, bank and accumulator/carry load ports each take effect at the next edge. An accumulator load is applied only in a cycle with no valid instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_we_i | input | 1 | Load the character pointer |
| src_i | input | 8 | New pointer value {chip, register, character} |
| bank_we_i | input | 1 | Load the bank selector |
| bank_i | input | 3 | New bank value |
| acc_we_i | input | 1 | Write back accumulator and carry |
| acc_i | input | 4 | Accumulator write-back value |
| cy_i | input | 1 | Carry write-back value |
| op_valid_i | input | 1 | Opcode valid strobe |
| opcode_i | input | 8 | Decoded instruction byte |
| acc_o | output | 4 | Accumulator |
| carry_o | output | 1 | Carry/link |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default parameters. These are 4-bit nibbles, 8 banks, 4 chips, 4 registers and 16 characters, which gives 2048 data characters and 512 status nibbles. With these defaults every addressing field has more than one value. The bench can therefore flip bank, chip, register and character one at a time and show that neighbouring characters stay apart. The 4-bit width puts the carry boundary at 15/16 and the borrow boundary at equal operands, so both are driven directly.

// File: rtl/nram_pkg.sv
package nram_pkg;
  localparam int OPC_W  = 8;
  localparam int STAT_W = 2;  // status index lives in opcode[1:0]

  typedef enum logic [2:0] {
    OP_NONE, OP_WRM, OP_RDM, OP_ADD, OP_SUB, OP_WRS, OP_RDS
  } op_e;

  function automatic op_e decode_op(input logic [OPC_W-1:0] opc);
    op_e r;
    casez (opc)
      8'b1110_0000: r = OP_WRM;
      8'b1110_1001: r = OP_RDM;
      8'b1110_1000: r = OP_ADD;
      8'b1110_1010: r = OP_SUB;
      8'b1110_01??: r = OP_WRS;
      8'b1110_11??: r = OP_RDS;
      default:      r = OP_NONE;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/nram_store.sv
module nram_store #(
  parameter int DATA_W = 4,
  parameter int ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 2 ** ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/nram_adder.sv
module nram_adder #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W-1:0] b_eff;
  logic         c_eff;
  logic [W:0]   full;

  // subtract = add complemented operand and complemented carry
  assign b_eff = sub_i ? ~b_i : b_i;
  assign c_eff = sub_i ? ~cin_i : cin_i;
  assign full  = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
  assign sum_o  = full[W-1:0];
  assign cout_o = full[W];
endmodule

// File: rtl/nram_exec_unit.sv
module nram_exec_unit #(
  parameter int NIB_W  = 4,
  parameter int BANK_W = 3,
  parameter int CHIP_W = 2,
  parameter int REG_W  = 2,
  parameter int CHAR_W = 4,
  localparam int SRC_W = CHIP_W + REG_W + CHAR_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       src_we_i,
  input  logic [SRC_W-1:0]           src_i,
  input  logic                       bank_we_i,
  input  logic [BANK_W-1:0]          bank_i,
  input  logic                       acc_we_i,
  input  logic [NIB_W-1:0]           acc_i,
  input  logic                       cy_i,
  input  logic                       op_valid_i,
  input  logic [nram_pkg::OPC_W-1:0] opcode_i,
  output logic [NIB_W-1:0]           acc_o,
  output logic                       carry_o,
  output logic                       done_o
);
  import nram_pkg::*;

  localparam int DADDR_W = BANK_W + SRC_W;
  localparam int SADDR_W = BANK_W + CHIP_W + REG_W + STAT_W;

  logic [NIB_W-1:0]  acc_q;
  logic              cy_q;
  logic [SRC_W-1:0]  src_q;
  logic [BANK_W-1:0] bank_q;
  logic              done_q;

  op_e               op;
  logic [NIB_W-1:0]  mem_rd, stat_rd, sum;
  logic              cout;
  logic [DADDR_W-1:0] d_addr;
  logic [SADDR_W-1:0] s_addr;

  assign op     = op_valid_i ? decode_op(opcode_i) : OP_NONE;
  assign d_addr = {bank_q, src_q};
  assign s_addr = {bank_q, src_q[SRC_W-1:CHAR_W], opcode_i[STAT_W-1:0]};

  nram_store #(.DATA_W(NIB_W), .ADDR_W(DADDR_W)) i_data (
    .clk_i  (clk_i),
    .we_i   (op == OP_WRM),
    .addr_i (d_addr),
    .wdata_i(acc_q),
    .rdata_o(mem_rd)
  );

  nram_store #(.DATA_W(NIB_W), .ADDR_W(SADDR_W)) i_stat (
    .clk_i  (clk_i),
    .we_i   (op == OP_WRS),
    .addr_i (s_addr),
    .wdata_i(acc_q),
    .rdata_o(stat_rd)
  );

  nram_adder #(.W(NIB_W)) i_add (
    .a_i   (acc_q),
    .b_i   (mem_rd),
    .cin_i (cy_q),
    .sub_i (op == OP_SUB),
    .sum_o (sum),
    .cout_o(cout)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      cy_q   <= 1'b0;
      src_q  <= '0;
      bank_q <= '0;
      done_q <= 1'b0;
    end else begin
      if (src_we_i)  src_q  <= src_i;
      if (bank_we_i) bank_q <= bank_i;
      done_q <= (op != OP_NONE);
      unique case (op)
        OP_RDM: acc_q <= mem_rd;
        OP_RDS: acc_q <= stat_rd;
        OP_ADD, OP_SUB: begin
          acc_q <= sum;
          cy_q  <= cout;
        end
        OP_WRM, OP_WRS: ;
        default: if (acc_we_i && !op_valid_i) begin
          acc_q <= acc_i;
          cy_q  <= cy_i;
        end
      endcase
    end
  end

  assign acc_o   = acc_q;
  assign carry_o = cy_q;
  assign done_o  = done_q;

  // R3
  wrm_keeps_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && opcode_i == 8'hE0) |=> ($stable(acc_o) && $stable(carry_o)));
  // R4
  rdm_keeps_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && opcode_i == 8'hE9) |=> $stable(carry_o));
  // R8
  wrs_keeps_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && opcode_i[7:2] == 6'b1110_01) |=> ($stable(acc_o) && $stable(carry_o)));
  // R9
  done_follows_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && decode_op(opcode_i) != OP_NONE) |=> done_o);
  // R9
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |=> !done_o);
  // R10
  unknown_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && decode_op(opcode_i) == OP_NONE) |=>
      (!done_o && $stable(acc_o) && $stable(carry_o)));
endmodule

// File: tb/test_nram_exec_unit.sv
module test_nram_exec_unit;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       src_we_i = 1'b0, bank_we_i = 1'b0, acc_we_i = 1'b0;
  logic [7:0] src_i = '0;
  logic [2:0] bank_i = '0;
  logic [3:0] acc_i = '0;
  logic       cy_i = 1'b0, op_valid_i = 1'b0;
  logic [7:0] opcode_i = '0;
  logic [3:0] acc_o;
  logic       carry_o, done_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  nram_exec_unit i_nram_exec_unit (.*);

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_ptr(logic [2:0] b, logic [7:0] s);
    @(negedge clk_i);
    bank_we_i = 1; bank_i = b; src_we_i = 1; src_i = s;
    @(negedge clk_i);
    bank_we_i = 0; src_we_i = 0;
  endtask

  task automatic load_acc(logic [3:0] a, logic c);
    @(negedge clk_i);
    acc_we_i = 1; acc_i = a; cy_i = c;
    @(negedge clk_i);
    acc_we_i = 0;
  endtask

  // drive one instruction; returns at the negedge after the executing edge
  task automatic run_op(logic [7:0] op);
    @(negedge clk_i);
    op_valid_i = 1; opcode_i = op;
    @(negedge clk_i);
    op_valid_i = 0;
  endtask

  task automatic put(logic [2:0] b, logic [7:0] s, logic [3:0] v);
    set_ptr(b, s);
    load_acc(v, 1'b0);
    run_op(8'hE0);
  endtask

  task automatic get_chk(string req, logic [2:0] b, logic [7:0] s, int exp);
    set_ptr(b, s);
    run_op(8'hE9);
    chk(req, acc_o, exp);
  endtask

  task automatic t_reset;
    chk("R1 acc", acc_o, 0);
    chk("R1 carry", carry_o, 0);
    chk("R1 done", done_o, 0);
    load_acc(4'd6, 1'b0);
    run_op(8'hE0);             // pointer and bank still at reset value 0
    set_ptr(3'd5, 8'hFF);
    load_acc(4'd0, 1'b0);
    get_chk("R1 pointer/bank zero", 3'd0, 8'h00, 6);
  endtask

  task automatic t_wrm_rdm;
    set_ptr(3'd2, 8'h5A);
    load_acc(4'd9, 1'b1);
    chk("R11 acc load", acc_o, 9);
    chk("R11 carry load", carry_o, 1);
    run_op(8'hE0);
    chk("R3 acc kept", acc_o, 9);
    chk("R3 carry kept", carry_o, 1);
    chk("R9 done high", done_o, 1);
    @(negedge clk_i);
    chk("R9 done one cycle", done_o, 0);
    load_acc(4'd0, 1'b1);
    run_op(8'hE9);
    chk("R4 read", acc_o, 9);
    chk("R4 carry kept", carry_o, 1);
  endtask

  task automatic t_addr;
    put(3'd2, 8'h5A, 4'd1);
    put(3'd3, 8'h5A, 4'd2);    // bank differs
    put(3'd2, 8'h9A, 4'd3);    // chip differs
    put(3'd2, 8'h6A, 4'd4);    // register differs
    put(3'd2, 8'h5B, 4'd5);    // character differs
    get_chk("R2 base", 3'd2, 8'h5A, 1);
    get_chk("R2 bank", 3'd3, 8'h5A, 2);
    get_chk("R2 chip", 3'd2, 8'h9A, 3);
    get_chk("R2 register", 3'd2, 8'h6A, 4);
    get_chk("R2 character", 3'd2, 8'h5B, 5);
  endtask

  task automatic arith(string req, logic [7:0] op, int a, int c, int m);
    int full, ea, ec;
    full = (op == 8'hE8) ? a + m + c : a + (15 - m) + (1 - c);
    ea = full % 16;
    ec = full / 16;
    put(3'd1, 8'h37, m[3:0]);
    load_acc(a[3:0], c[0]);
    run_op(op);
    chk({req, " acc"}, acc_o, ea);
    chk({req, " carry"}, carry_o, ec);
    get_chk("R7 memory untouched", 3'd1, 8'h37, m);
  endtask

  task automatic t_add;
    arith("R5 9+8+1", 8'hE8, 9, 1, 8);
    arith("R5 7+8+0 edge", 8'hE8, 7, 0, 8);
    arith("R5 7+8+1 edge", 8'hE8, 7, 1, 8);
    arith("R5 0+0+0", 8'hE8, 0, 0, 0);
  endtask

  task automatic t_sub;
    arith("R6 5-3 no borrow", 8'hEA, 5, 0, 3);
    arith("R6 3-5 borrow", 8'hEA, 3, 0, 5);
    arith("R6 5-3 pending", 8'hEA, 5, 1, 3);
    arith("R6 4-4 pending", 8'hEA, 4, 1, 4);
    arith("R6 4-4", 8'hEA, 4, 0, 4);
  endtask

  task automatic t_status;
    put(3'd4, 8'hC7, 4'd11);
    for (int i = 0; i < 4; i++) begin
      load_acc(4'(i + 12), 1'b0);
      run_op(8'hE4 | 8'(i));
    end
    set_ptr(3'd4, 8'hD7);      // other register
    load_acc(4'd1, 1'b0);
    run_op(8'hE5);
    set_ptr(3'd4, 8'hC7);
    for (int i = 0; i < 4; i++) begin
      load_acc(4'd0, 1'b0);
      run_op(8'hEC | 8'(i));
      chk("R8 status read", acc_o, i + 12);
    end
    get_chk("R8 data separate", 3'd4, 8'hC7, 11);
  endtask

  task automatic t_unknown;
    logic [7:0] ops [4] = '{8'hE3, 8'hE2, 8'h00, 8'hF0};
    put(3'd6, 8'h10, 4'd7);
    for (int i = 0; i < 4; i++) begin
      load_acc(4'd3, 1'b1);
      run_op(ops[i]);
      chk("R10 no done", done_o, 0);
      chk("R10 acc kept", acc_o, 3);
      chk("R10 carry kept", carry_o, 1);
    end
    get_chk("R10 memory kept", 3'd6, 8'h10, 7);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset;
    t_wrm_rdm;
    t_addr;
    t_add;
    t_sub;
    t_status;
    t_unknown;
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule